// File: doc/BRIEF.md
# Sample Pacing Buffer

This block sits between a filter engine that can produce samples in bursts, for example while it runs an interpolation pass, and a consumer that needs the samples evenly spread in time. The engine writes 24-bit samples with a one-cycle strobe, one per cycle at most and several in a row if it likes. They are held in a four-entry first-in first-out store. The samples leave under control of a spacing counter, not on a request from downstream, so the consumer does no handshaking.

The spacing is a 12-bit value N, counted in clock periods. A value of 0 stands for 4096; any other value stands for itself. After each release the counter reloads, and the next release cannot come sooner than N cycles later. If the store is empty when the counter runs out, the pacer raises a sticky underflow flag and waits. The first sample to arrive then goes straight to the output. A spacing of 1 therefore behaves as a fall-through path. If a write reaches a full store while nothing is leaving, the new sample is dropped and a sticky overflow flag is set. One clear pulse resets both flags.

The pacing controller is a four-state machine. PS_IDLE is the state after reset, before any release. PS_HOLD counts down the reload. PS_DUE is the cycle in which the counter has expired. PS_STARVED is entered when PS_DUE found nothing to send. Any release moves the machine to PS_HOLD (N > 1) or PS_DUE (N = 1). In PS_HOLD, a count of 1 moves it to PS_DUE; otherwise it decrements. PS_DUE with no sample moves to PS_STARVED and flags underflow. PS_IDLE and PS_STARVED stay put until a sample is available.

Top module: `sample_pacer`

## Requirements
- R1: While reset is held and in the first cycle after it is released, out_valid, ovf_flag and udf_flag are 0 and the store is empty.
- R2: When the store is empty and the pacer is not counting down (PS_IDLE, PS_DUE or PS_STARVED), a written sample appears on out_data with out_valid high right after the clock edge that takes the write. With N = 1 this happens every cycle.
- R3: Two out_valid pulses are never less than N cycles apart. While samples are waiting, they are exactly N cycles apart.
- R4: A spacing value of 0 gives a gap of 4096 cycles. Values 1 to 4095 give a gap of that many cycles.
- R5: The store holds up to four samples that are not yet released, besides any sample that goes out at the moment it is written.
- R6: A write to a full store in a cycle with no release drops the sample and sets ovf_flag. ovf_flag stays set until cleared.
- R7: A write to a full store in the same cycle as a release is accepted. ovf_flag does not change.
- R8: If the counter expires while the store is empty and no write is present, no out_valid pulse is issued and udf_flag is set and stays set. The next sample written is released right after its write edge.
- R9: A one-cycle pulse on clr_flags clears ovf_flag and udf_flag. If a new event arrives in the same cycle, the event wins.
- R10: Samples leave in the order they were written. out_data keeps the last released value between pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | One-cycle write strobe from the filter engine |
| wr_data | input | 24 | Sample to write |
| spacing | input | 12 | Release spacing in cycles; 0 means 4096 |
| clr_flags | input | 1 | Clears both sticky flags |
| out_data | output | 24 | Released sample |
| out_valid | output | 1 | One-cycle pulse for each release |
| ovf_flag | output | 1 | Sticky: a sample was dropped |
| udf_flag | output | 1 | Sticky: the counter expired with nothing to send |

## Verification
The hardest case to reach is a write that lands on a full store in exactly the cycle the counter expires. Being one cycle early or late turns R7 into an R6 drop. The stimulus gets there by starting from reset, where the schedule of releases is known. It writes one sample that falls through, fills the store on the next four edges, idles for one cycle, and writes again on the sixth edge with a spacing of 6. Underflow at expiry is reached in the same way, by letting a known backlog drain and waiting one full spacing period.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
    localparam int unsigned PACER_DATA_W    = 24;
    localparam int unsigned PACER_DEPTH     = 4;
    localparam int unsigned PACER_SPACING_W = 12;

    typedef enum logic [1:0] {
        PS_IDLE    = 2'd0,
        PS_HOLD    = 2'd1,
        PS_DUE     = 2'd2,
        PS_STARVED = 2'd3
    } pace_state_t;
endpackage

// File: rtl/pacer_store.sv
module pacer_store #(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] head,
    output logic [CW-1:0]     count
);
    logic [DATA_W-1:0] slots [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (push && wr_ptr == AW'(g))
                    slots[g] <= din;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_inc(wr_ptr);
            if (pop)  rd_ptr <= ptr_inc(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head = slots[rd_ptr];
endmodule

// File: rtl/pacer_spacing_ctl.sv
module pacer_spacing_ctl
    import pacer_pkg::*;
#(
    parameter int unsigned SPACING_W = 12,
    localparam int unsigned NW       = SPACING_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 avail,
    input  logic [SPACING_W-1:0] spacing,
    output logic                 release_now,
    output logic                 udf_evt
);
    pace_state_t          state, state_nx;
    logic [SPACING_W-1:0] cnt, cnt_nx;
    logic [NW-1:0]        eff_n;

    // zero encodes the largest spacing, 2**SPACING_W
    assign eff_n = (spacing == '0) ? NW'(1) << SPACING_W : {1'b0, spacing};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PS_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // outputs
    always_comb begin
        release_now = 1'b0;
        udf_evt     = 1'b0;
        unique case (state)
            PS_HOLD:    release_now = 1'b0;
            PS_DUE: begin
                release_now = avail;
                udf_evt     = !avail;
            end
            PS_IDLE,
            PS_STARVED: release_now = avail;
            default:    release_now = 1'b0;
        endcase
    end

    // next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (release_now) begin
            cnt_nx   = SPACING_W'(eff_n - 1'b1);
            state_nx = (eff_n == NW'(1)) ? PS_DUE : PS_HOLD;
        end else begin
            unique case (state)
                PS_HOLD: begin
                    if (cnt == SPACING_W'(1)) state_nx = PS_DUE;
                    else                      cnt_nx   = cnt - 1'b1;
                end
                PS_DUE:     state_nx = PS_STARVED;
                PS_IDLE,
                PS_STARVED: state_nx = state;
                default:    state_nx = PS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sample_pacer.sv
module sample_pacer
    import pacer_pkg::*;
#(
    parameter int unsigned DATA_W    = PACER_DATA_W,
    parameter int unsigned DEPTH     = PACER_DEPTH,
    parameter int unsigned SPACING_W = PACER_SPACING_W,
    localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [SPACING_W-1:0] spacing,
    input  logic                 clr_flags,
    output logic [DATA_W-1:0]    out_data,
    output logic                 out_valid,
    output logic                 ovf_flag,
    output logic                 udf_flag
);
    logic [DATA_W-1:0] head;
    logic [CW-1:0]     fifo_cnt;
    logic              empty, full, avail, release_now, udf_evt;
    logic              bypass, push, pop, ovf_evt;

    assign empty   = (fifo_cnt == '0);
    assign full    = (fifo_cnt == CW'(DEPTH));
    assign avail   = !empty || wr_en;
    assign bypass  = release_now && empty;
    assign pop     = release_now && !empty;
    assign push    = wr_en && !bypass && (!full || pop);
    assign ovf_evt = wr_en && full && !pop;

    pacer_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (wr_data),
        .head  (head),
        .count (fifo_cnt)
    );

    pacer_spacing_ctl #(.SPACING_W(SPACING_W)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .avail       (avail),
        .spacing     (spacing),
        .release_now (release_now),
        .udf_evt     (udf_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            ovf_flag  <= 1'b0;
            udf_flag  <= 1'b0;
        end else begin
            out_valid <= release_now;
            if (release_now)
                out_data <= bypass ? wr_data : head;
            if (ovf_evt)        ovf_flag <= 1'b1;
            else if (clr_flags) ovf_flag <= 1'b0;
            if (udf_evt)        udf_flag <= 1'b1;
            else if (clr_flags) udf_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/sample_pacer_chk.sv
module sample_pacer_chk #(
    parameter int unsigned DEPTH     = 4,
    parameter int unsigned SPACING_W = 12,
    localparam int unsigned CW       = $clog2(DEPTH + 1),
    localparam int unsigned NW       = SPACING_W + 1,
    localparam int unsigned GW       = SPACING_W + 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 clr_flags,
    input logic [SPACING_W-1:0] spacing,
    input logic                 out_valid,
    input logic                 ovf_flag,
    input logic                 udf_flag,
    input logic [CW-1:0]        fifo_cnt,
    input logic                 pop
);
    logic [GW-1:0] gap;
    logic [NW-1:0] last_n;
    logic          seen;
    logic [NW-1:0] eff_n;

    assign eff_n = (spacing == '0) ? NW'(1) << SPACING_W : {1'b0, spacing};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap    <= '0;
            last_n <= '0;
            seen   <= 1'b0;
        end else if (out_valid) begin
            gap    <= GW'(1);
            last_n <= eff_n;
            seen   <= 1'b1;
        end else if (gap != '1) begin
            gap <= gap + 1'b1;
        end
    end

    // R3
    min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen) |-> (gap >= GW'(last_n)));

    // R5
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH));

    // R6
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fifo_cnt == CW'(DEPTH) && !pop) |=> ovf_flag);

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_flags) |=> ovf_flag);

    // R7
    full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fifo_cnt == CW'(DEPTH) && pop) |=> (fifo_cnt == CW'(DEPTH)));

    // R8
    udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (udf_flag && !clr_flags) |=> udf_flag);

    // R9
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flags && !wr_en) |=> !ovf_flag);
endmodule

bind sample_pacer sample_pacer_chk #(.DEPTH(DEPTH), .SPACING_W(SPACING_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .clr_flags (clr_flags),
    .spacing   (spacing),
    .out_valid (out_valid),
    .ovf_flag  (ovf_flag),
    .udf_flag  (udf_flag),
    .fifo_cnt  (fifo_cnt),
    .pop       (pop)
);

// File: tb/tb_sample_pacer.sv
module tb_sample_pacer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [23:0] wr_data;
    logic [11:0] spacing;
    logic        clr_flags;
    logic [23:0] out_data;
    logic        out_valid, ovf_flag, udf_flag;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int np     = 0;
    int pt [16];
    logic [23:0] pd [16];

    always #2.5 clk = ~clk;

    sample_pacer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .spacing(spacing), .clr_flags(clr_flags), .out_data(out_data),
        .out_valid(out_valid), .ovf_flag(ovf_flag), .udf_flag(udf_flag)
    );

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (out_valid && np < 16) begin
        pt[np] = cyc; pd[np] = out_data; np = np + 1;
    end

    // per-cycle vectors at spacing 3: {wr, wdata, exp_valid, exp_data, exp_udf}
    localparam logic [18:0] VEC [21] = '{
        {1'b1, 8'h11, 1'b1, 8'h11, 1'b0},
        {1'b1, 8'h22, 1'b0, 8'h00, 1'b0},
        {1'b1, 8'h33, 1'b0, 8'h00, 1'b0},
        {1'b0, 8'h00, 1'b1, 8'h22, 1'b0},
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b0},
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b0},
        {1'b0, 8'h00, 1'b1, 8'h33, 1'b0},
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b0},
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b0},
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b1},
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b1},
        {1'b1, 8'h44, 1'b1, 8'h44, 1'b1},
        {1'b1, 8'h55, 1'b0, 8'h00, 1'b1},
        {1'b1, 8'h66, 1'b0, 8'h00, 1'b1},
        {1'b1, 8'h77, 1'b1, 8'h55, 1'b1},
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b1},
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b1},
        {1'b0, 8'h00, 1'b1, 8'h66, 1'b1},
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b1},
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b1},
        {1'b0, 8'h00, 1'b1, 8'h77, 1'b1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [11:0] sp);
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; clr_flags = 1'b0; spacing = sp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        np = 0;
    endtask

    task automatic drive(input logic we, input logic [23:0] d);
        wr_en = we; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail = n_fail + 1;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset(12'd3);
        // R1 reset state, held and just after release
        check(!out_valid && !ovf_flag && !udf_flag, "R1 reset outputs", {out_valid, ovf_flag, udf_flag}, 0);

        // table walk: R2 fall-through, R3 spacing, R8 underflow, R10 order
        for (int i = 0; i < 21; i++) begin
            wr_en = VEC[i][18]; wr_data = {3{VEC[i][17:10]}};
            @(negedge clk);
            check(out_valid == VEC[i][9], "R3 valid timing (table)", out_valid, VEC[i][9]);
            if (VEC[i][9])
                check(out_data == {3{VEC[i][8:1]}}, "R10 release order (table)", out_data, {3{VEC[i][8:1]}});
            check(udf_flag == VEC[i][0], "R8 underflow flag (table)", udf_flag, VEC[i][0]);
            check(!ovf_flag, "R6 no overflow in table", ovf_flag, 0);
        end
        wr_en = 1'b0;
        check(out_data == {3{8'h77}}, "R10 out_data held", out_data, {3{8'h77}});

        // R9 clear
        clr_flags = 1'b1; @(negedge clk); clr_flags = 1'b0;
        check(!udf_flag, "R9 udf cleared", udf_flag, 0);

        // R2 fall-through at spacing 1, then R8 underflow on expiry
        do_reset(12'd1);
        for (int i = 0; i < 5; i++) begin
            wr_en = 1'b1; wr_data = 24'hD0_0000 + 24'(i);
            @(negedge clk);
            check(out_valid && out_data == 24'hD0_0000 + 24'(i), "R2 fall-through", out_data, 24'hD0_0000 + i);
        end
        wr_en = 1'b0; @(negedge clk);
        check(!out_valid && udf_flag, "R8 underflow at spacing 1", {out_valid, udf_flag}, 1);

        // R5/R6: one falls through, four stored, sixth dropped
        do_reset(12'd50);
        for (int i = 1; i <= 6; i++) drive(1'b1, 24'hA0_0000 + 24'(i));
        check(ovf_flag, "R6 overflow set", ovf_flag, 1);
        idle(260);
        check(np == 5, "R5 four stored plus one fall-through", np, 5);
        for (int i = 0; i < 5 && i < np; i++)
            check(pd[i] == 24'hA0_0000 + 24'(i + 1), "R10 order after burst", pd[i], 24'hA0_0000 + i + 1);
        for (int i = 1; i < 5 && i < np; i++)
            check(pt[i] - pt[i-1] == 50, "R3 exact spacing with backlog", pt[i] - pt[i-1], 50);
        check(ovf_flag && udf_flag, "R6 overflow sticky", {ovf_flag, udf_flag}, 3);
        clr_flags = 1'b1; @(negedge clk); clr_flags = 1'b0;
        check(!ovf_flag && !udf_flag, "R9 both flags cleared", {ovf_flag, udf_flag}, 0);

        // R7: write into full store on the release cycle
        do_reset(12'd6);
        for (int i = 1; i <= 5; i++) drive(1'b1, 24'hB0_0000 + 24'(i));
        idle(1);
        drive(1'b1, 24'hB0_0006);
        check(!ovf_flag, "R7 no overflow on swap", ovf_flag, 0);
        idle(40);
        check(np == 6, "R7 all six released", np, 6);
        for (int i = 0; i < 6 && i < np; i++)
            check(pd[i] == 24'hB0_0000 + 24'(i + 1), "R7 order with swap", pd[i], 24'hB0_0000 + i + 1);
        check(!ovf_flag, "R7 overflow still clear", ovf_flag, 0);

        // R4: spacing 0 means 4096
        do_reset(12'd0);
        drive(1'b1, 24'hC0_0001);
        drive(1'b1, 24'hC0_0002);
        idle(4100);
        check(np == 2, "R4 two pulses", np, 2);
        if (np == 2) check(pt[1] - pt[0] == 4096, "R4 gap for zero code", pt[1] - pt[0], 4096);

        // R4: large explicit code
        do_reset(12'd4095);
        drive(1'b1, 24'hC1_0001);
        drive(1'b1, 24'hC1_0002);
        idle(4100);
        if (np == 2) check(pt[1] - pt[0] == 4095, "R4 gap for 4095", pt[1] - pt[0], 4095);
        else check(1'b0, "R4 pulses for 4095", np, 2);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule